// File: doc/BRIEF.md
# Four-Channel Phase-Coherent Sine Synthesizer with Profile Modulation

The block generates four sine waves from one clock. Each channel keeps a 32-bit phase accumulator that advances by that channel's frequency tuning word on every rising edge. A 14-bit phase offset is added to the top of the accumulator, and the top ten bits of the sum address a sine table that stores only one quarter of a wave. The signed sample is scaled by a 10-bit amplitude factor and leaves the channel as a 10-bit offset-binary code for a DAC. All channels share the clock and commit new settings together, so their relative phase stays fixed.

Every channel also holds a sixteen-entry profile table. A 2-bit mode field picks which parameter the table replaces: amplitude, frequency or phase. A 4-bit per-channel select input then picks the entry. This gives 16-level ASK, FSK or PSK that an external source drives from pins. The select inputs pass through two flip-flops before use. A simple write port fills a shadow copy of every word. A single update strobe moves all shadow copies into the working set at once. A per-channel clear input forces an accumulator to zero, so channels can be realigned.

Top module: `dds4_core`

## Requirements
- R1: After reset every output reads 512, and it stays at 512 until the first update strobe, because all committed words reset to zero.
- R2: A write selects a channel with `wr_ch`. The address map is: 0 is the tuning word (32 bits), 1 is the phase offset (low 14 bits), 2 is the amplitude scale (low 10 bits), 3 is the mode (low 2 bits), and 16 to 31 hold profile entry `addr-16` (32 bits). Addresses 4 to 15 are ignored. A written value changes nothing at the output until an update strobe.
- R3: One update strobe commits the shadow words of every channel in the same cycle. An output first shows the new settings after the third rising edge that follows the edge sampling the strobe.
- R4: The accumulator adds the tuning word once per clock, modulo 2^32. With scale 1023 and offset 0, a word of 2^30 gives the repeating period-4 sequence 512, 1022, 512, 1 in some rotation, and a word of 2^31 gives a constant 512.
- R5: The phase offset is added, modulo 2^14, to the top 14 accumulator bits. The top 10 bits of that sum address the sine, so the low 4 offset bits alone do not move the output.
- R6: The output is 512 + floor(S*A/1024). A is the scale, and S is within 2 of 511*sin(2*pi*a/1024) for table address a. S is exactly 0, 511, 0 and -511 at a = 0, 256, 512 and 768, so outputs stay within 1 to 1022.
- R7: A scale of 0 gives 512 at any phase. A scale of 1 gives 512 at a = 256 and 511 at a = 768.
- R8: While a channel's clear bit is high, its accumulator is held at zero. Channels with equal settings whose clears are released in the same cycle produce identical outputs from then on.
- R9: The mode field selects what the profile table drives. 00 uses the base words and ignores the select inputs. 01 takes the scale from the entry's low 10 bits. 10 takes the full 32-bit entry as the tuning word. 11 takes the phase offset from the entry's low 14 bits.
- R10: A change on a channel's 4-bit profile select appears at its output after the fifth rising edge following the change, and not earlier.
- R11: Writes and commits addressed to one channel leave every other channel's output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared synthesis clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the shadow words |
| wr_ch | input | 2 | Target channel of a write |
| wr_addr | input | 5 | Word address within the channel |
| wr_data | input | 32 | Write data |
| update | input | 1 | Commits all shadow words into the working set |
| acc_clear | input | 4 | Per-channel accumulator clear, bit n for channel n |
| profile_sel | input | 16 | Per-channel profile index, bits 4n+3..4n for channel n |
| dac_out | output | 40 | Offset-binary samples, bits 10n+9..10n for channel n |

## Verification
The synthesis path is checked with the accumulator frozen by clear, so the phase offset alone sets a static output. Cardinal offsets pin down the exact table points and the sign handling of the quarter-wave folding. Non-cardinal offsets and the sub-address offset bits show that the sum is taken from the top bits. Running tuning words of a quarter and a half turn separate correct accumulation from a stuck or mis-sliced accumulator. Mode sweeps, with tables that differ from the base words, show which parameter each mode substitutes and that mode 00 ignores the pins. Cycle-exact sampling around the update strobe and the profile pins tells a correct pipeline depth apart from one register too few or too many.

// File: rtl/dds4_pkg.sv
package dds4_pkg;
  localparam int DDS_NUM_CH = 4;
  localparam int DDS_ACC_W  = 32;
  localparam int DDS_POFF_W = 14;
  localparam int DDS_AMP_W  = 10;
  localparam int DDS_OUT_W  = 10;
  localparam int DDS_PROF_W = 4;
  localparam int DDS_LUT_AW = 10;

  // What the profile table substitutes for the base word
  typedef enum logic [1:0] {
    MOD_OFF   = 2'b00,
    MOD_AMP   = 2'b01,
    MOD_FREQ  = 2'b10,
    MOD_PHASE = 2'b11
  } mod_sel_e;
endpackage

// File: rtl/dds_pin_sync.sv
module dds_pin_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/dds_cfg_bank.sv
module dds_cfg_bank
  import dds4_pkg::*;
#(
  parameter int ACC_W  = DDS_ACC_W,
  parameter int POFF_W = DDS_POFF_W,
  parameter int AMP_W  = DDS_AMP_W,
  parameter int PROF_W = DDS_PROF_W,
  parameter int ADDR_W = DDS_PROF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ACC_W-1:0]  wr_data,
  input  logic              update,
  input  logic [PROF_W-1:0] prof,
  output logic [ACC_W-1:0]  ftw_o,
  output logic [POFF_W-1:0] poff_o,
  output logic [AMP_W-1:0]  amp_o
);
  localparam int NPROF = 2 ** PROF_W;

  typedef struct packed {
    logic [ACC_W-1:0]  ftw;
    logic [POFF_W-1:0] poff;
    logic [AMP_W-1:0]  amp;
    logic [1:0]        mode;
  } words_t;

  words_t           sh_q, sh_d, ac_q, ac_d;
  logic [ACC_W-1:0] stab_q [NPROF];
  logic [ACC_W-1:0] stab_d [NPROF];
  logic [ACC_W-1:0] atab_q [NPROF];
  logic [ACC_W-1:0] atab_d [NPROF];
  logic             is_tab;
  logic             base_hit;
  logic [ACC_W-1:0] sel_word;

  assign is_tab   = wr_addr[ADDR_W-1];
  assign base_hit = (wr_addr[ADDR_W-2:2] == '0);

  // shadow next state
  always_comb begin
    sh_d   = sh_q;
    stab_d = stab_q;
    if (wr_en) begin
      if (is_tab) begin
        stab_d[wr_addr[PROF_W-1:0]] = wr_data;
      end else if (base_hit) begin
        case (wr_addr[1:0])
          2'd0:    sh_d.ftw  = wr_data;
          2'd1:    sh_d.poff = wr_data[POFF_W-1:0];
          2'd2:    sh_d.amp  = wr_data[AMP_W-1:0];
          default: sh_d.mode = wr_data[1:0];
        endcase
      end
    end
  end

  // working set next state
  always_comb begin
    ac_d   = ac_q;
    atab_d = atab_q;
    if (update) begin
      ac_d   = sh_q;
      atab_d = stab_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      ac_q <= '0;
      for (int i = 0; i < NPROF; i++) begin
        stab_q[i] <= '0;
        atab_q[i] <= '0;
      end
    end else begin
      sh_q   <= sh_d;
      ac_q   <= ac_d;
      stab_q <= stab_d;
      atab_q <= atab_d;
    end
  end

  assign sel_word = atab_q[prof];

  always_comb begin
    ftw_o  = ac_q.ftw;
    poff_o = ac_q.poff;
    amp_o  = ac_q.amp;
    case (mod_sel_e'(ac_q.mode))
      MOD_AMP:   amp_o  = sel_word[AMP_W-1:0];
      MOD_FREQ:  ftw_o  = sel_word;
      MOD_PHASE: poff_o = sel_word[POFF_W-1:0];
      default:   ;
    endcase
  end
endmodule

// File: rtl/dds_sine_lut.sv
module dds_sine_lut #(
  parameter int LUT_AW = 10,
  parameter int OUT_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LUT_AW-1:0]       phase,
  output logic signed [OUT_W:0]   samp
);
  localparam int QN    = 2 ** (LUT_AW - 2);
  localparam int HN    = 2 * QN;
  localparam int MAG_W = OUT_W - 1;
  localparam int AMAX  = 2 ** (OUT_W - 1) - 1;
  localparam int TAB_W = (QN + 1) * MAG_W;

  // rational half-wave approximation, exact at 0, quarter and half turn
  function automatic logic [TAB_W-1:0] build_tab();
    logic [TAB_W-1:0] t;
    longint u;
    longint v;
    t = '0;
    for (int k = 0; k <= QN; k++) begin
      u = longint'(k) * longint'(HN - k);
      v = (longint'(AMAX) * 16 * u) / (5 * longint'(HN) * longint'(HN) - 4 * u);
      t[k*MAG_W +: MAG_W] = MAG_W'(v);
    end
    return t;
  endfunction

  localparam logic [TAB_W-1:0] QTAB = build_tab();

  logic [1:0]              quad;
  logic [LUT_AW-3:0]       idx;
  logic [LUT_AW-2:0]       mag_idx;
  logic [MAG_W-1:0]        mag;
  logic signed [OUT_W:0]   samp_d;
  logic signed [OUT_W:0]   samp_q;

  assign quad    = phase[LUT_AW-1:LUT_AW-2];
  assign idx     = phase[LUT_AW-3:0];
  assign mag_idx = quad[0] ? ((LUT_AW-1)'(QN) - {1'b0, idx}) : {1'b0, idx};
  assign mag     = QTAB[mag_idx*MAG_W +: MAG_W];

  always_comb begin
    if (quad[1]) samp_d = -$signed({2'b00, mag});
    else         samp_d =  $signed({2'b00, mag});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) samp_q <= '0;
    else        samp_q <= samp_d;
  end

  assign samp = samp_q;
endmodule

// File: rtl/dds_channel.sv
module dds_channel #(
  parameter int ACC_W  = 32,
  parameter int POFF_W = 14,
  parameter int AMP_W  = 10,
  parameter int OUT_W  = 10,
  parameter int LUT_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [ACC_W-1:0]  ftw,
  input  logic [POFF_W-1:0] poff,
  input  logic [AMP_W-1:0]  amp,
  output logic [OUT_W-1:0]  dac
);
  localparam int PW = OUT_W + AMP_W + 2;
  localparam logic signed [PW-1:0] MID_S   = PW'(2 ** (OUT_W - 1));
  localparam logic [OUT_W-1:0]     MID_OUT = OUT_W'(2 ** (OUT_W - 1));

  logic [ACC_W-1:0]        acc_q, acc_d;
  logic [POFF_W-1:0]       ph_sum;
  logic [LUT_AW-1:0]       addr_q, addr_d;
  logic [AMP_W-1:0]        amp1_q, amp2_q;
  logic signed [OUT_W:0]   samp;
  logic signed [PW-1:0]    prod;
  logic signed [PW-1:0]    shifted;
  logic [OUT_W-1:0]        dac_q, dac_d;
  logic                    unused_ph_bits;

  // stage 0: accumulator
  assign acc_d = clr ? '0 : (acc_q + ftw);

  // stage 1: phase offset and table address
  assign ph_sum         = acc_q[ACC_W-1 -: POFF_W] + poff;
  assign addr_d         = ph_sum[POFF_W-1 -: LUT_AW];
  assign unused_ph_bits = ^ph_sum[POFF_W-LUT_AW-1:0];

  // stage 2: quarter-wave lookup (registered inside)
  dds_sine_lut #(
    .LUT_AW(LUT_AW),
    .OUT_W (OUT_W)
  ) lut_i (
    .clk  (clk),
    .rst_n(rst_n),
    .phase(addr_q),
    .samp (samp)
  );

  // stage 3: scale and re-bias
  assign prod    = PW'(samp * $signed({1'b0, amp2_q}));
  assign shifted = prod >>> AMP_W;
  assign dac_d   = OUT_W'(shifted + MID_S);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      addr_q <= '0;
      amp1_q <= '0;
      amp2_q <= '0;
      dac_q  <= MID_OUT;
    end else begin
      acc_q  <= acc_d;
      addr_q <= addr_d;
      amp1_q <= amp;
      amp2_q <= amp1_q;
      dac_q  <= dac_d;
    end
  end

  assign dac = dac_q;
endmodule

// File: rtl/dds4_core.sv
module dds4_core
  import dds4_pkg::*;
#(
  parameter int NUM_CH = DDS_NUM_CH,
  parameter int ACC_W  = DDS_ACC_W,
  parameter int POFF_W = DDS_POFF_W,
  parameter int AMP_W  = DDS_AMP_W,
  parameter int OUT_W  = DDS_OUT_W,
  parameter int PROF_W = DDS_PROF_W,
  parameter int LUT_AW = DDS_LUT_AW,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = PROF_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [CH_W-1:0]          wr_ch,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [ACC_W-1:0]         wr_data,
  input  logic                     update,
  input  logic [NUM_CH-1:0]        acc_clear,
  input  logic [NUM_CH*PROF_W-1:0] profile_sel,
  output logic [NUM_CH*OUT_W-1:0]  dac_out
);
  logic [NUM_CH*PROF_W-1:0] prof_sync;

  dds_pin_sync #(
    .W(NUM_CH * PROF_W)
  ) prof_sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (profile_sel),
    .q    (prof_sync)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic              ch_wr;
    logic [ACC_W-1:0]  ftw_e;
    logic [POFF_W-1:0] poff_e;
    logic [AMP_W-1:0]  amp_e;

    assign ch_wr = wr_en && (wr_ch == CH_W'(c));

    dds_cfg_bank #(
      .ACC_W (ACC_W),
      .POFF_W(POFF_W),
      .AMP_W (AMP_W),
      .PROF_W(PROF_W),
      .ADDR_W(ADDR_W)
    ) cfg_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (ch_wr),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .update (update),
      .prof   (prof_sync[c*PROF_W +: PROF_W]),
      .ftw_o  (ftw_e),
      .poff_o (poff_e),
      .amp_o  (amp_e)
    );

    dds_channel #(
      .ACC_W (ACC_W),
      .POFF_W(POFF_W),
      .AMP_W (AMP_W),
      .OUT_W (OUT_W),
      .LUT_AW(LUT_AW)
    ) chan_i (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (acc_clear[c]),
      .ftw  (ftw_e),
      .poff (poff_e),
      .amp  (amp_e),
      .dac  (dac_out[c*OUT_W +: OUT_W])
    );
  end
endmodule

// File: rtl/dds4_core_chk.sv
module dds4_core_chk #(
  parameter int NUM_CH = 4,
  parameter int OUT_W  = 10,
  parameter int PROF_W = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     update,
  input logic [NUM_CH-1:0]        acc_clear,
  input logic [NUM_CH*PROF_W-1:0] profile_sel,
  input logic [NUM_CH*OUT_W-1:0]  dac_out
);
  localparam logic [OUT_W-1:0] MID = OUT_W'(2 ** (OUT_W - 1));
  localparam logic [OUT_W-1:0] TOP = OUT_W'(2 ** OUT_W - 2);

  logic                     upd_seen_q;
  logic [NUM_CH*PROF_W-1:0] prof_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_seen_q  <= 1'b0;
      prof_prev_q <= '0;
    end else begin
      upd_seen_q  <= upd_seen_q | update;
      prof_prev_q <= profile_sel;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic [2:0] quiet_q;
    logic       quiet_now;

    assign quiet_now = acc_clear[c] && !update &&
                       (profile_sel[c*PROF_W +: PROF_W] == prof_prev_q[c*PROF_W +: PROF_W]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            quiet_q <= '0;
      else if (!quiet_now)   quiet_q <= '0;
      else if (quiet_q != 3'd7) quiet_q <= quiet_q + 3'd1;
    end

    // R6
    out_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dac_out[c*OUT_W +: OUT_W] != '0);

    // R6
    out_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dac_out[c*OUT_W +: OUT_W] <= TOP);

    // R1
    idle_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_seen_q |-> (dac_out[c*OUT_W +: OUT_W] == MID));

    // R2 R10
    quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_q >= 3'd6) |-> $stable(dac_out[c*OUT_W +: OUT_W]));
  end
endmodule

bind dds4_core dds4_core_chk #(
  .NUM_CH(NUM_CH),
  .OUT_W (OUT_W),
  .PROF_W(PROF_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .update     (update),
  .acc_clear  (acc_clear),
  .profile_sel(profile_sel),
  .dac_out    (dac_out)
);

// File: tb/dds4_core_tb_top.sv
module dds4_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_ch;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data;
  logic        update;
  logic [3:0]  acc_clear;
  logic [15:0] profile_sel;
  logic [39:0] dac_out;

  int checks;
  int errors;

  dds4_core dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_ch      (wr_ch),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .update     (update),
    .acc_clear  (acc_clear),
    .profile_sel(profile_sel),
    .dac_out    (dac_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int outv(int c);
    return int'(dac_out[c*10 +: 10]);
  endfunction

  // expected output from the sine/scale requirement
  function automatic int exp_val(int addr, int amp);
    real s;
    int  si;
    int  p;
    int  q;
    s  = 511.0 * $sin(2.0 * 3.141592653589793 * addr / 1024.0);
    si = (s >= 0.0) ? $rtoi(s + 0.5) : -$rtoi(-s + 0.5);
    p  = si * amp;
    q  = (p >= 0) ? (p / 1024) : -((-p + 1023) / 1024);
    return 512 + q;
  endfunction

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic chk_tol(string req, int act, int expv, int tol);
    checks++;
    if (act < expv - tol || act > expv + tol) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d +/- %0d", req, act, expv, tol);
    end
  endtask

  task automatic wr(int c, int a, logic [31:0] d);
    wr_en   = 1'b1;
    wr_ch   = 2'(c);
    wr_addr = 5'(a);
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic commit();
    update = 1'b1;
    @(negedge clk);
    update = 1'b0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_prof(int c, int p);
    profile_sel[c*4 +: 4] = 4'(p);
  endtask

  task automatic t_reset();
    for (int c = 0; c < 4; c++) chk("R1 reset output", outv(c), 512);
    settle(4);
    chk("R1 idle before update", outv(2), 512);
  endtask

  task automatic t_shadow_commit();
    wr(0, 2, 32'd1023);
    wr(0, 1, 32'd4096);
    wr(1, 2, 32'd1023);
    wr(1, 1, 32'd12288);
    settle(6);
    chk("R2 shadow write no effect ch0", outv(0), 512);
    chk("R2 shadow write no effect ch1", outv(1), 512);
    update = 1'b1;
    @(negedge clk);
    update = 1'b0;
    settle(2);
    chk("R3 before third edge ch0", outv(0), 512);
    chk("R3 before third edge ch1", outv(1), 512);
    settle(1);
    chk("R3 at third edge ch0", outv(0), 1022);
    chk("R3 at third edge ch1", outv(1), 1);
    chk("R11 untouched ch2", outv(2), 512);
    chk("R11 untouched ch3", outv(3), 512);
    wr(0, 5, 32'hFFFF_FFFF);
    wr(0, 12, 32'hFFFF_FFFF);
    commit();
    settle(5);
    chk("R2 unmapped address ignored", outv(0), 1022);
  endtask

  task automatic t_phase();
    int offs [7] = '{0, 4096, 8192, 12288, 15, 1360, 5000};
    int expv [5] = '{512, 1022, 512, 1, 512};
    wr(0, 2, 32'd1023);
    for (int i = 0; i < 7; i++) begin
      wr(0, 1, 32'(offs[i]));
      commit();
      settle(5);
      if (i < 5) chk("R5 R6 static phase exact", outv(0), expv[i]);
      else chk_tol("R5 R6 static phase approx", outv(0), exp_val(offs[i] >> 4, 1023), 2);
    end
  endtask

  task automatic t_amp();
    int poffs [4] = '{4096, 4096, 12288, 4096};
    int amps  [4] = '{0, 512, 512, 1};
    int expv  [4] = '{512, 767, 256, 512};
    for (int i = 0; i < 4; i++) begin
      wr(0, 1, 32'(poffs[i]));
      wr(0, 2, 32'(amps[i]));
      commit();
      settle(5);
      chk(i == 0 ? "R7 zero scale" : (i == 3 ? "R7 unit scale" : "R6 half scale"), outv(0), expv[i]);
    end
    wr(0, 1, 32'd12288);
    commit();
    settle(5);
    chk("R7 unit scale negative", outv(0), 511);
    wr(0, 1, 32'd8192);
    wr(0, 2, 32'd0);
    commit();
    settle(5);
    chk("R7 zero scale half turn", outv(0), 512);
  endtask

  task automatic run_pattern(int c, string req, output int hi, output int lo, output int bad);
    int s [8];
    hi = 0; lo = 0; bad = 0;
    for (int i = 0; i < 8; i++) begin
      s[i] = outv(c);
      @(negedge clk);
    end
    for (int i = 0; i < 4; i++) begin
      if (s[i] != s[i+4]) bad++;
      if (s[i] == 1022) hi++;
      else if (s[i] == 1) lo++;
      else if (s[i] != 512) bad++;
    end
  endtask

  task automatic t_freq();
    int hi, lo, bad;
    wr(2, 2, 32'd1023);
    wr(2, 1, 32'd0);
    wr(2, 0, 32'h4000_0000);
    commit();
    acc_clear[2] = 1'b0;
    settle(6);
    run_pattern(2, "R4", hi, lo, bad);
    chk("R4 quarter-turn peaks", hi, 1);
    chk("R4 quarter-turn troughs", lo, 1);
    chk("R4 quarter-turn period", bad, 0);
    wr(2, 0, 32'h8000_0000);
    commit();
    settle(6);
    run_pattern(2, "R4", hi, lo, bad);
    chk("R4 half-turn flat", hi + lo + bad, 0);
    chk("R4 half-turn value", outv(2), 512);
    acc_clear[2] = 1'b1;
    settle(2);
  endtask

  task automatic t_clear();
    int diff;
    for (int c = 0; c < 4; c += 3) begin
      wr(c, 0, 32'h0123_4567);
      wr(c, 1, 32'd0);
      wr(c, 2, 32'd1023);
      wr(c, 3, 32'd0);
    end
    commit();
    acc_clear[0] = 1'b0;
    settle(7);
    acc_clear[3] = 1'b0;
    settle(5);
    diff = 0;
    for (int i = 0; i < 16; i++) begin
      if (outv(0) != outv(3)) diff++;
      @(negedge clk);
    end
    checks++;
    if (diff == 0) begin
      errors++;
      $display("FAIL R8 staggered channels differ actual %0d expected >0", diff);
    end
    acc_clear[0] = 1'b1;
    acc_clear[3] = 1'b1;
    settle(2);
    acc_clear[0] = 1'b0;
    acc_clear[3] = 1'b0;
    settle(4);
    diff = 0;
    for (int i = 0; i < 16; i++) begin
      if (outv(0) != outv(3)) diff++;
      @(negedge clk);
    end
    chk("R8 realigned mismatches", diff, 0);
    acc_clear = 4'hF;
    settle(2);
  endtask

  task automatic t_modes();
    int ph_exp  [4] = '{512, 1022, 512, 1};
    int hi, lo, bad;
    // phase mode
    wr(1, 0, 32'd0);
    wr(1, 1, 32'd0);
    wr(1, 2, 32'd1023);
    for (int p = 0; p < 16; p++) wr(1, 16 + p, 32'((p % 4) * 4096));
    wr(1, 3, 32'd3);
    commit();
    for (int p = 0; p < 4; p++) begin
      set_prof(1, p);
      settle(7);
      chk("R9 phase mode entry", outv(1), ph_exp[p]);
    end
    // off mode: pins ignored
    wr(1, 3, 32'd0);
    commit();
    set_prof(1, 1);
    settle(7);
    chk("R9 off mode ignores select", outv(1), 512);
    // amplitude mode
    for (int p = 0; p < 16; p++) wr(1, 16 + p, 32'(p * 64));
    wr(1, 1, 32'd4096);
    wr(1, 3, 32'd1);
    commit();
    set_prof(1, 0);
    settle(7);
    chk("R9 amplitude mode entry 0", outv(1), 512);
    set_prof(1, 8);
    settle(7);
    chk("R9 amplitude mode entry 8", outv(1), 767);
    set_prof(1, 15);
    settle(7);
    chk("R9 amplitude mode entry 15", outv(1), exp_val(256, 960));
    // frequency mode
    wr(1, 16, 32'd0);
    wr(1, 21, 32'h4000_0000);
    wr(1, 1, 32'd0);
    wr(1, 3, 32'd2);
    commit();
    set_prof(1, 0);
    acc_clear[1] = 1'b0;
    settle(7);
    chk("R9 frequency mode zero word", outv(1), 512);
    set_prof(1, 5);
    settle(7);
    run_pattern(1, "R9", hi, lo, bad);
    chk("R9 frequency mode entry 5 pattern", hi * 100 + lo * 10 + bad, 110);
    acc_clear[1] = 1'b1;
    set_prof(1, 0);
    settle(3);
  endtask

  task automatic t_prof_latency();
    for (int p = 0; p < 4; p++) wr(1, 16 + p, 32'(p * 4096));
    wr(1, 2, 32'd1023);
    wr(1, 3, 32'd3);
    commit();
    set_prof(1, 0);
    settle(8);
    chk("R10 settled entry 0", outv(1), 512);
    set_prof(1, 1);
    settle(4);
    chk("R10 unchanged after four edges", outv(1), 512);
    settle(1);
    chk("R10 changed after fifth edge", outv(1), 1022);
    chk("R11 other channel unaffected", outv(2), 512);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks      = 0;
    errors      = 0;
    rst_n       = 1'b0;
    wr_en       = 1'b0;
    wr_ch       = '0;
    wr_addr     = '0;
    wr_data     = '0;
    update      = 1'b0;
    acc_clear   = 4'hF;
    profile_sel = '0;
    settle(3);
    rst_n = 1'b1;
    settle(2);
    t_reset();
    t_shadow_commit();
    t_phase();
    t_amp();
    t_freq();
    t_clear();
    t_modes();
    t_prof_latency();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule